// File: doc/BRIEF.md
# Write-Protected Real-Time Clock Register Front End

This block sits between a simple 32-bit word-addressed bus and a real-time clock core. It decodes reads and writes, holds the control, debounce, alarm-status and alarm-control registers, and routes the time and alarm field registers to a field load/read port on the calendar core. The calendar arithmetic itself lives behind that port. Each field is one byte. The block drives an interrupt line from the alarm status and the alarm enable.

All functional registers are write-protected after reset. Software must first write seven key bytes, in a fixed order, to seven key offsets. Until then, writes at offset 0x20 and above have no effect, but reads return the real register contents. Once the sequence completes, the block stays unlocked until the next reset.

Each access is acknowledged exactly one cycle after it is presented. Field reads pass the core's live value straight through, with no snapshot. Software can therefore read the second field before and after the other fields to detect a tick.

Top module: `rtc_regfront`

## Requirements
- R1: Every request (`req_valid` high for one cycle) is answered by `bus_ack` high in the next cycle, with the read data on `rsp_rdata` in that same cycle. `bus_ack` stays low when no request was made. Write responses carry zero data.
- R2: The block unlocks after these seven writes, in this order, with the value in the low byte: 0xC6 at 0x04, 0x9A at 0x08, 0x59 at 0x0C, 0xA3 at 0x10, 0x57 at 0x14, 0x67 at 0x18, 0xD2 at 0x1C. It then stays unlocked until reset.
- R3: While the block is locked, a key-offset write that has the wrong value or is out of order sends the unlock progress back to the start. Once unlocked, writes to key offsets are ignored. Key offsets always read as zero.
- R4: While the block is locked, writes to offsets 0x20 and above change nothing: no register and no core field. Reads still return the current contents. Reset re-locks the block.
- R5: Offset 0x20 bit 0 is the counter-stop bit (`cnt_stop`), which resets to 1. Offset 0x2C bits 2:0 hold the debounce setting (`deb_cfg`), which resets to 7; upper data bits are dropped.
- R6: Offset 0x30 bit 4 is the alarm status. An `alarm_hit` pulse sets it. Writing 1 to bit 4 clears it, and writing 0 leaves it alone. If a hit and a clear arrive in the same cycle, the hit wins. It resets to 0.
- R7: Offset 0x7C holds the 8-bit alarm control register (`alarm_cfg`), which resets to 0. Bit 0 is the alarm enable. `irq` is high exactly when the alarm status is 1 and the enable bit is 1.
- R8: The field at offset 0x40 + 4*idx + 0x20*set maps to the core field with index idx (0 year, 1 month, 2 day of month, 3 day of week, 4 hour, 5 minute, 6 second) and set (0 time, 1 alarm). A write, once unlocked, pulses `fld_wr` with the low data byte. A read returns the core's current value.
- R9: Unmapped offsets read as zero and ignore writes. This covers misaligned addresses and the 0x5C slot. It also covers 0x00 and any offset not listed in R2 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed, one cycle after the request |
| rsp_rdata | output | 32 | Read data, valid with `bus_ack` |
| fld_sel | output | 1 | Field set selected: 0 time, 1 alarm |
| fld_idx | output | 3 | Field index selected |
| fld_wr | output | 1 | Field load strobe to the core |
| fld_wdata | output | 8 | Field load value |
| fld_rdata | input | 8 | Live value of the selected core field |
| alarm_hit | input | 1 | Alarm match pulse from the core |
| cnt_stop | output | 1 | Stops the time counter when 1 |
| deb_cfg | output | 3 | Debounce setting |
| alarm_cfg | output | 8 | Alarm control register contents |
| irq | output | 1 | Alarm interrupt |

## Verification
A wrong unlock counter shows up in one of two ways. Either a functional register changes while it should be protected, or it stays unchanged after a correct sequence. Both are visible by reading the register back on the access right after the write. A status flag held in the wrong state shows on `irq` in the cycle after the event and on the next read of offset 0x30. A wrong field decode sends a load to the wrong core field. That becomes visible when the intended field and a neighbouring field are read back, one cycle per read.

// File: rtl/rtc_regfront_pkg.sv
// Package: offsets, key schedule and field constants shared by the
// register front end. Assumes byte offsets and 32-bit word alignment.
package rtc_regfront_pkg;
    localparam int N_KEYS      = 7;      // key writes needed to unlock
    localparam int KEY_BASE    = 'h04;   // first key offset, stride 4
    localparam int OFF_CTL     = 'h20;
    localparam int OFF_DEB     = 'h2C;
    localparam int OFF_STS     = 'h30;
    localparam int OFF_ALM     = 'h7C;
    localparam int FIELD_BASE  = 'h40;
    localparam int FIELD_SPAN  = 'h40;   // two sets of 0x20 each
    localparam int N_FIELDS    = 7;
    localparam int STS_BIT     = 4;

    typedef enum logic {SET_TIME = 1'b0, SET_ALARM = 1'b1} fld_set_e;

    // Key byte expected at a given step of the unlock sequence.
    function automatic logic [7:0] key_value(input int step);
        case (step)
            0: key_value = 8'hC6;
            1: key_value = 8'h9A;
            2: key_value = 8'h59;
            3: key_value = 8'hA3;
            4: key_value = 8'h57;
            5: key_value = 8'h67;
            6: key_value = 8'hD2;
            default: key_value = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/rtc_unlock_seq.sv
// Unlock sequencer: counts correct key writes in order and raises
// `unlocked` after the last one. Assumes wr_en is one request cycle.
module rtc_unlock_seq
    import rtc_regfront_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    output logic              unlocked
);
    localparam int STEP_W = $clog2(N_KEYS + 1);
    localparam int KEY_LAST = KEY_BASE + 4 * (N_KEYS - 1);

    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] exp_addr;
    logic              is_key;

    assign unlocked = (step == STEP_W'(N_KEYS));
    assign exp_addr = ADDR_W'(KEY_BASE + 4 * int'(step));
    assign is_key   = (wr_addr[1:0] == 2'b00) &&
                      (wr_addr >= ADDR_W'(KEY_BASE)) && (wr_addr <= ADDR_W'(KEY_LAST));

    // Advance on the expected key, fall back to the start on any other key write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (wr_en && is_key && !unlocked) begin
            if (wr_addr == exp_addr && wr_byte == key_value(int'(step)))
                step <= step + STEP_W'(1);
            else
                step <= '0;
        end
    end

    // R3: progress only moves by one, stays, or restarts.
    a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (step == '0 || step == $past(step) || step == $past(step) + STEP_W'(1)));
    // R2: once unlocked, stays unlocked until reset.
    a_r2_stays_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);
endmodule

// File: rtl/rtc_ctrl_regs.sv
// Control state: counter stop, debounce, alarm status (write-1-clear)
// and alarm control, plus the interrupt. Write strobes arrive pre-gated.
module rtc_ctrl_regs
    import rtc_regfront_pkg::*;
#(
    parameter int DEB_W = 3,
    parameter int ALM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_deb,
    input  logic             wr_sts,
    input  logic             wr_alm,
    input  logic [7:0]       wbyte,
    input  logic             alarm_hit,
    output logic             stop,
    output logic [DEB_W-1:0] deb,
    output logic             sts,
    output logic [ALM_W-1:0] alm,
    output logic             irq
);
    // Counter stop bit; stopped out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      stop <= 1'b1;
        else if (wr_ctl) stop <= wbyte[0];
    end

    // Debounce setting; maximum out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      deb <= '1;
        else if (wr_deb) deb <= wbyte[DEB_W-1:0];
    end

    // Alarm status: set by a hit, cleared by writing 1; a hit wins.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= 1'b0;
        else        sts <= alarm_hit | (sts & ~(wr_sts & wbyte[STS_BIT]));
    end

    // Alarm control register.
    always_ff @(posedge clk) begin
        if (!rst_n)      alm <= '0;
        else if (wr_alm) alm <= wbyte[ALM_W-1:0];
    end

    assign irq = sts & alm[0];

    // R6: status rises only after a hit.
    a_r6_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> $past(alarm_hit));
    // R6: a hit always leaves the status set.
    a_r6_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> sts);
    // R6: clear without a hit empties the status.
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wbyte[STS_BIT] && !alarm_hit) |=> !sts);
endmodule

// File: rtl/rtc_field_map.sv
// Field decoder: turns a byte offset into a set/index pair for the
// calendar core and qualifies field loads. Assumes loads arrive pre-gated.
module rtc_field_map
    import rtc_regfront_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int FLD_W  = 8
) (
    input  logic              [ADDR_W-1:0] addr,
    input  logic                           wr_en,
    input  logic              [FLD_W-1:0]  wbyte,
    output logic                           hit,
    output fld_set_e                       sel,
    output logic              [2:0]        idx,
    output logic                           fld_wr,
    output logic              [FLD_W-1:0]  fld_wdata
);
    logic [ADDR_W-1:0] off;
    logic              in_rng;
    logic              unused_off;

    assign off        = addr - ADDR_W'(FIELD_BASE);
    assign in_rng     = (addr >= ADDR_W'(FIELD_BASE)) &&
                        (addr <  ADDR_W'(FIELD_BASE + FIELD_SPAN));
    assign sel        = fld_set_e'(off[5]);
    assign idx        = off[4:2];
    assign hit        = in_rng && (off[1:0] == 2'b00) && (idx < 3'(N_FIELDS));
    assign fld_wr     = wr_en && hit;
    assign fld_wdata  = wbyte;
    assign unused_off = ^off[ADDR_W-1:6];
endmodule

// File: rtl/rtc_regfront.sv
// Register front end of the real-time clock: decodes bus accesses,
// applies write protection, returns read data one cycle later.
// Assumes one request per cycle at most and a combinational fld_rdata.
module rtc_regfront
    import rtc_regfront_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int FLD_W  = 8,
    parameter int DEB_W  = 3,
    parameter int ALM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fld_sel,
    output logic [2:0]        fld_idx,
    output logic              fld_wr,
    output logic [FLD_W-1:0]  fld_wdata,
    input  logic [FLD_W-1:0]  fld_rdata,
    input  logic              alarm_hit,
    output logic              cnt_stop,
    output logic [DEB_W-1:0]  deb_cfg,
    output logic [ALM_W-1:0]  alarm_cfg,
    output logic              irq
);
    logic              wr_any, wr_func, rd_any, unlocked;
    logic              is_ctl, is_deb, is_sts, is_alm, is_fld;
    logic              sts;
    fld_set_e          sel_e;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wd;

    assign wr_any    = req_valid & req_write;
    assign rd_any    = req_valid & ~req_write;
    assign wr_func   = wr_any & unlocked;
    assign is_ctl    = (req_addr == ADDR_W'(OFF_CTL));
    assign is_deb    = (req_addr == ADDR_W'(OFF_DEB));
    assign is_sts    = (req_addr == ADDR_W'(OFF_STS));
    assign is_alm    = (req_addr == ADDR_W'(OFF_ALM));
    assign fld_sel   = sel_e;
    assign unused_wd = ^req_wdata[DATA_W-1:8];

    rtc_unlock_seq #(.ADDR_W(ADDR_W)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_any),
        .wr_addr  (req_addr),
        .wr_byte  (req_wdata[7:0]),
        .unlocked (unlocked)
    );

    rtc_ctrl_regs #(.DEB_W(DEB_W), .ALM_W(ALM_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_func & is_ctl),
        .wr_deb    (wr_func & is_deb),
        .wr_sts    (wr_func & is_sts),
        .wr_alm    (wr_func & is_alm),
        .wbyte     (req_wdata[7:0]),
        .alarm_hit (alarm_hit),
        .stop      (cnt_stop),
        .deb       (deb_cfg),
        .sts       (sts),
        .alm       (alarm_cfg),
        .irq       (irq)
    );

    rtc_field_map #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_fmap (
        .addr      (req_addr),
        .wr_en     (wr_func),
        .wbyte     (req_wdata[FLD_W-1:0]),
        .hit       (is_fld),
        .sel       (sel_e),
        .idx       (fld_idx),
        .fld_wr    (fld_wr),
        .fld_wdata (fld_wdata)
    );

    // Read multiplexer; anything unmapped returns zero.
    always_comb begin
        rd_mux = '0;
        if (is_ctl)      rd_mux = DATA_W'(cnt_stop);
        else if (is_deb) rd_mux = DATA_W'(deb_cfg);
        else if (is_sts) rd_mux = DATA_W'(sts) << STS_BIT;
        else if (is_alm) rd_mux = DATA_W'(alarm_cfg);
        else if (is_fld) rd_mux = DATA_W'(fld_rdata);
    end

    // One-cycle response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            bus_ack   <= req_valid;
            rsp_rdata <= rd_any ? rd_mux : '0;
        end
    end

    // R1: every request is acknowledged in the next cycle, and only then.
    a_r1_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> bus_ack);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !bus_ack);
    // R4: a locked control write leaves the stop bit unchanged.
    a_r4_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !unlocked && is_ctl) |=> $stable(cnt_stop));
    // R8: core field loads only happen once unlocked.
    a_r8_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
        fld_wr |-> unlocked);
endmodule

// File: tb/rtc_regfront_tb.sv
`timescale 1ns/1ps
module rtc_regfront_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        bus_ack;
    logic [31:0] rsp_rdata;
    logic        fld_sel, fld_wr;
    logic [2:0]  fld_idx;
    logic [7:0]  fld_wdata, fld_rdata;
    logic        alarm_hit = 1'b0;
    logic        cnt_stop, irq;
    logic [2:0]  deb_cfg;
    logic [7:0]  alarm_cfg;
    logic        tick_req = 1'b0;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    rtc_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_ack(bus_ack),
        .rsp_rdata(rsp_rdata), .fld_sel(fld_sel), .fld_idx(fld_idx),
        .fld_wr(fld_wr), .fld_wdata(fld_wdata), .fld_rdata(fld_rdata),
        .alarm_hit(alarm_hit), .cnt_stop(cnt_stop), .deb_cfg(deb_cfg),
        .alarm_cfg(alarm_cfg), .irq(irq)
    );

    // Calendar core stand-in: two sets of seven byte fields, second ticks on request.
    logic [7:0] core_f [2][7];
    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 7; i++) core_f[s][i] = 8'h00;
    end
    always @(posedge clk) begin
        if (fld_wr && fld_idx < 3'd7) core_f[fld_sel][fld_idx] <= fld_wdata;
        if (tick_req) core_f[0][6] <= core_f[0][6] + 8'd1;
    end
    assign fld_rdata = (fld_idx < 3'd7) ? core_f[fld_sel][fld_idx] : 8'h00;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 54;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h20, 32'h0, 32'h1, 4'd5},       // R5 stop resets to 1
        '{1'b0, 8'h2C, 32'h0, 32'h7, 4'd5},       // R5 debounce resets to 7
        '{1'b0, 8'h7C, 32'h0, 32'h0, 4'd7},       // R7 alarm ctl resets to 0
        '{1'b0, 8'h30, 32'h0, 32'h0, 4'd6},       // R6 status resets to 0
        '{1'b1, 8'h20, 32'h0, 32'h0, 4'd4},
        '{1'b0, 8'h20, 32'h0, 32'h1, 4'd4},       // R4 locked write dropped
        '{1'b1, 8'h7C, 32'hFF, 32'h0, 4'd4},
        '{1'b0, 8'h7C, 32'h0, 32'h0, 4'd4},       // R4 locked alarm ctl write dropped
        '{1'b1, 8'h40, 32'h55, 32'h0, 4'd4},      // locked field write
        '{1'b1, 8'h04, 32'hC6, 32'h0, 4'd3},
        '{1'b1, 8'h08, 32'h9A, 32'h0, 4'd3},
        '{1'b1, 8'h0C, 32'h00, 32'h0, 4'd3},      // wrong value
        '{1'b1, 8'h10, 32'hA3, 32'h0, 4'd3},
        '{1'b1, 8'h14, 32'h57, 32'h0, 4'd3},
        '{1'b1, 8'h18, 32'h67, 32'h0, 4'd3},
        '{1'b1, 8'h1C, 32'hD2, 32'h0, 4'd3},
        '{1'b1, 8'h20, 32'h0, 32'h0, 4'd3},
        '{1'b0, 8'h20, 32'h0, 32'h1, 4'd3},       // R3 still locked
        '{1'b1, 8'h04, 32'hC6, 32'h0, 4'd3},
        '{1'b1, 8'h0C, 32'h59, 32'h0, 4'd3},      // out of order
        '{1'b1, 8'h04, 32'hC6, 32'h0, 4'd2},
        '{1'b1, 8'h08, 32'h9A, 32'h0, 4'd2},
        '{1'b1, 8'h0C, 32'h59, 32'h0, 4'd2},
        '{1'b1, 8'h10, 32'hA3, 32'h0, 4'd2},
        '{1'b1, 8'h14, 32'h57, 32'h0, 4'd2},
        '{1'b1, 8'h18, 32'h67, 32'h0, 4'd2},
        '{1'b1, 8'h1C, 32'hD2, 32'h0, 4'd2},
        '{1'b1, 8'h20, 32'h0, 32'h0, 4'd2},
        '{1'b0, 8'h20, 32'h0, 32'h0, 4'd2},       // R2 unlocked, stop cleared
        '{1'b0, 8'h40, 32'h0, 32'h0, 4'd4},       // R4 locked field write never reached core
        '{1'b1, 8'h2C, 32'h5, 32'h0, 4'd5},
        '{1'b0, 8'h2C, 32'h0, 32'h5, 4'd5},
        '{1'b1, 8'h2C, 32'hFFFF_FFF2, 32'h0, 4'd5},
        '{1'b0, 8'h2C, 32'h0, 32'h2, 4'd5},       // R5 only bits 2:0 kept
        '{1'b0, 8'h04, 32'h0, 32'h0, 4'd3},       // R3 key offset reads zero
        '{1'b1, 8'h7C, 32'h1FF, 32'h0, 4'd7},
        '{1'b0, 8'h7C, 32'h0, 32'hFF, 4'd7},      // R7 eight bits kept
        '{1'b0, 8'h00, 32'h0, 32'h0, 4'd9},       // R9
        '{1'b1, 8'h24, 32'hFF, 32'h0, 4'd9},
        '{1'b0, 8'h24, 32'h0, 32'h0, 4'd9},       // R9
        '{1'b1, 8'h42, 32'h77, 32'h0, 4'd9},      // misaligned write
        '{1'b0, 8'h40, 32'h0, 32'h0, 4'd9},       // R9 year untouched
        '{1'b1, 8'h40, 32'h17, 32'h0, 4'd8},
        '{1'b0, 8'h40, 32'h0, 32'h17, 4'd8},      // R8 time year
        '{1'b1, 8'h78, 32'h3B, 32'h0, 4'd8},
        '{1'b0, 8'h78, 32'h0, 32'h3B, 4'd8},      // R8 alarm second
        '{1'b0, 8'h58, 32'h0, 32'h0, 4'd8},       // R8 time second separate
        '{1'b1, 8'h5C, 32'hFF, 32'h0, 4'd9},
        '{1'b0, 8'h5C, 32'h0, 32'h0, 4'd9},       // R9 gap slot
        '{1'b1, 8'h40, 32'hFFFF_FF18, 32'h0, 4'd8},
        '{1'b0, 8'h40, 32'h0, 32'h18, 4'd8},      // R8 low byte only
        '{1'b1, 8'h20, 32'h1, 32'h0, 4'd5},
        '{1'b0, 8'h20, 32'h0, 32'h1, 4'd5},       // R5 stop set
        '{1'b1, 8'h20, 32'h0, 32'h0, 4'd5}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus access; samples the response at the following falling edge.
    task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic hit, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; alarm_hit = hit;
        @(negedge clk);
        req_valid = 1'b0; alarm_hit = 1'b0;
        check("R1 ack", {31'b0, bus_ack}, 32'h1);
        if (wr) check("R1 write data zero", rsp_rdata, 32'h0);
        rd = rsp_rdata;
    endtask

    task automatic reset_dut();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] rd;
        reset_dut();
        check("R1 idle", {31'b0, bus_ack}, 32'h0);
        check("R7 irq after reset", {31'b0, irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            bus(VEC[k].wr, VEC[k].addr, VEC[k].data, 1'b0, rd);
            if (!VEC[k].wr) check($sformatf("R%0d vector %0d", VEC[k].req, k), rd, VEC[k].exp);
        end
        @(negedge clk);
        check("R1 no ack when idle", {31'b0, bus_ack}, 32'h0);
        check("R5 cnt_stop port", {31'b0, cnt_stop}, 32'h0);

        // R6 / R7: status set, read order, write-1-clear, hit wins, irq gating
        bus(1'b0, 8'h30, 32'h0, 1'b1, rd);
        check("R6 read before set", rd, 32'h0);
        check("R7 irq raised", {31'b0, irq}, 32'h1);
        bus(1'b0, 8'h30, 32'h0, 1'b0, rd);
        check("R6 status set", rd, 32'h10);
        bus(1'b1, 8'h30, 32'hEF, 1'b0, rd);
        bus(1'b0, 8'h30, 32'h0, 1'b0, rd);
        check("R6 write 0 keeps", rd, 32'h10);
        bus(1'b1, 8'h30, 32'h10, 1'b0, rd);
        bus(1'b0, 8'h30, 32'h0, 1'b0, rd);
        check("R6 write 1 clears", rd, 32'h0);
        check("R7 irq cleared", {31'b0, irq}, 32'h0);
        bus(1'b1, 8'h30, 32'h10, 1'b1, rd);
        bus(1'b0, 8'h30, 32'h0, 1'b0, rd);
        check("R6 hit wins over clear", rd, 32'h10);
        bus(1'b1, 8'h7C, 32'hFE, 1'b0, rd);
        check("R7 irq masked by enable", {31'b0, irq}, 32'h0);
        check("R7 alarm_cfg port", {24'b0, alarm_cfg}, 32'hFE);
        bus(1'b1, 8'h7C, 32'h01, 1'b0, rd);
        check("R7 irq enabled", {31'b0, irq}, 32'h1);

        // R8: live second read and set/index mapping
        bus(1'b1, 8'h58, 32'h2A, 1'b0, rd);
        bus(1'b0, 8'h58, 32'h0, 1'b0, rd);
        check("R8 second before tick", rd, 32'h2A);
        @(negedge clk); tick_req = 1'b1;
        @(negedge clk); tick_req = 1'b0;
        bus(1'b0, 8'h58, 32'h0, 1'b0, rd);
        check("R8 second live after tick", rd, 32'h2B);
        bus(1'b1, 8'h64, 32'h0C, 1'b0, rd);
        check("R8 alarm month in core", {24'b0, core_f[1][1]}, 32'h0C);
        check("R8 time month untouched", {24'b0, core_f[0][1]}, 32'h00);
        bus(1'b1, 8'h50, 32'h09, 1'b0, rd);
        check("R8 time hour in core", {24'b0, core_f[0][4]}, 32'h09);

        // R3: key writes after unlock are ignored
        bus(1'b1, 8'h04, 32'h00, 1'b0, rd);
        bus(1'b1, 8'h20, 32'h1, 1'b0, rd);
        bus(1'b0, 8'h20, 32'h0, 1'b0, rd);
        check("R3 still unlocked", rd, 32'h1);

        // R4: reset re-locks and restores defaults
        reset_dut();
        check("R5 stop after reset", {31'b0, cnt_stop}, 32'h1);
        check("R5 debounce after reset", {29'b0, deb_cfg}, 32'h7);
        bus(1'b1, 8'h20, 32'h0, 1'b0, rd);
        bus(1'b0, 8'h20, 32'h0, 1'b0, rd);
        check("R4 relocked after reset", rd, 32'h1);
        bus(1'b0, 8'h7C, 32'h0, 1'b0, rd);
        check("R7 alarm ctl after reset", rd, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule